// File: doc/BRIEF.md
# Half-Duplex Open-Drain Direction Arbiter

This block sits between a host-side and a card-side open-drain data line of a smart card link and works out at run time which side is talking. Both lines rest released (high). The first line seen to fall becomes the input. The block then pulls the other line low for as long as the input line stays low. When the input line rises again, both lines go back to the released state and a new exchange may start from either side.

The block only arbitrates while a card session is open and the activation sequencer has enabled reception. At any other time it holds the card-side line low and leaves the host-side line released. Line levels are brought into the clock domain through a two-flop synchroniser before any edge is detected. A watchdog counts how long the host-side line has been low. When that time passes a programmable limit of one character time, it raises a lockup flag so that the host can end and restart the session.

Top module: `io_dir_arbiter`

## Requirements
- R1: During and after reset, with the session input low, the card line is driven low, the host line is released, `dir_o` reads 0 (neutral) and `lockup_o` is 0.
- R2: The card line stays driven low while `session_i` or `rx_en_i` is low. It is released on the first rising clock edge that samples both high.
- R3: In neutral, a falling level on the host line moves `dir_o` to 1 (host drives card). The card line is then driven low and the host line is not. This takes effect at the third rising edge after the line changes.
- R4: In neutral, a falling level on the card line moves `dir_o` to 2 (card drives host). The host line is then driven low and the card line is not. The latency is the same as in R3.
- R5: A rising level on the current input line returns `dir_o` to 0 and releases both lines at the third rising edge after the change. Level changes on the output line during a transfer have no effect.
- R6: If both lines are seen to fall in the same sample, the host side wins and `dir_o` becomes 1.
- R7: The block never drives both lines low at the same time. A transfer stays in its direction until the input line rises, whatever the other side does.
- R8: If `session_i` or `rx_en_i` goes low, the next edge forces `dir_o` to 0, releases the host line, drives the card line low and clears `lockup_o`. Falls that occur while inactive are ignored, and a line that is already low at enable produces no transfer.
- R9: `lockup_o` rises when the synchronised host line has been low for more than `lock_limit_i` cycles, at the (limit+3)th rising edge after the line falls. It clears at the third edge after the host line rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_line_i | input | 1 | Sampled level of the host-side line |
| card_line_i | input | 1 | Sampled level of the card-side line |
| session_i | input | 1 | Card session active |
| rx_en_i | input | 1 | Reception enabled by the activation sequencer |
| lock_limit_i | input | CNT_W | Host-low cycle limit for the lockup flag |
| host_drive_low_o | output | 1 | Pull the host line low |
| card_drive_low_o | output | 1 | Pull the card line low |
| dir_o | output | 2 | 0 neutral, 1 host to card, 2 card to host |
| lockup_o | output | 1 | Host line held low past the limit |

## Verification
The bench targets the following corner cases:
- Both sides falling in the same cycle. A design without host priority would pick the card side or enter both directions.
- The card releasing its line while the host still holds a transfer. A design that releases on any rise would free the card line early.
- Dropping enable in the middle of a transfer. A design that did not force neutral would keep driving the host line.
- A line that is already low when reception is enabled. Level-triggered logic would start a false transfer.
- The exact cycle at which the drive appears and the exact cycle at which the lockup flag is crossed. These catch an extra or missing register stage and an off-by-one comparison against the limit.

// File: rtl/io_arb_pkg.sv
// Shared types for the direction arbiter.
package io_arb_pkg;
    typedef enum logic [1:0] {
        DIR_NEUTRAL = 2'd0,
        DIR_H2C     = 2'd1,
        DIR_C2H     = 2'd2
    } dir_e;
endpackage

// File: rtl/io_arb_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous line levels.
// Assumes lines rest high, so every stage resets to 1.
module io_arb_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Shift the level one stage further into the clock domain.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '1;
                else if (s == 0) stg[s] <= d_i;
                else stg[s] <= stg[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/io_arb_edge.sv
// Edge detector on one synchronised level. Assumes the previous level
// resets high, so no falling edge is seen on a released line at reset.
module io_arb_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic fall_o,
    output logic rise_o
);
    logic prev_q;

    // Keep last cycle's level for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= lvl_i;
    end

    assign fall_o = prev_q & ~lvl_i;
    assign rise_o = ~prev_q & lvl_i;
endmodule

// File: rtl/io_arb_fsm.sv
// Direction state machine. The first line to fall from neutral becomes
// the input (host wins a tie), and a rise on that line returns to neutral.
// Assumes active_i is synchronous to clk.
module io_arb_fsm
    import io_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic host_fall_i,
    input  logic host_rise_i,
    input  logic card_fall_i,
    input  logic card_rise_i,
    output dir_e dir_o
);
    dir_e st_q, st_d;

    // Next-state selection with forced neutral while inactive.
    always_comb begin
        st_d = st_q;
        if (!active_i) begin
            st_d = DIR_NEUTRAL;
        end else begin
            case (st_q)
                DIR_NEUTRAL: begin
                    if (host_fall_i)      st_d = DIR_H2C;
                    else if (card_fall_i) st_d = DIR_C2H;
                end
                DIR_H2C: if (host_rise_i) st_d = DIR_NEUTRAL;
                DIR_C2H: if (card_rise_i) st_d = DIR_NEUTRAL;
                default: st_d = DIR_NEUTRAL;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= DIR_NEUTRAL;
        else        st_q <= st_d;
    end

    assign dir_o = st_q;
endmodule

// File: rtl/io_arb_lockwd.sv
// Stuck-low watchdog for the host line. It counts cycles of low level,
// saturating at the top, and flags when the count exceeds the limit.
// The count clears when the line is high or the link is inactive.
module io_arb_lockwd #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic             low_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             lockup_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    logic [CNT_W-1:0] cnt_q;

    // Low-time counter with saturation.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt_q <= '0;
        else if (!active_i || !low_i)    cnt_q <= '0;
        else if (cnt_q != CNT_MAX)       cnt_q <= cnt_q + 1'b1;
    end

    assign lockup_o = (cnt_q > limit_i);
endmodule

// File: rtl/io_dir_arbiter.sv
// Top of the half-duplex direction arbiter. It synchronises both line
// levels, detects edges, runs the direction FSM and the host-low watchdog,
// and produces the open-drain pull-low enables. Assumes session_i and
// rx_en_i are synchronous to clk.
module io_dir_arbiter
    import io_arb_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_line_i,
    input  logic             card_line_i,
    input  logic             session_i,
    input  logic             rx_en_i,
    input  logic [CNT_W-1:0] lock_limit_i,
    output logic             host_drive_low_o,
    output logic             card_drive_low_o,
    output logic [1:0]       dir_o,
    output logic             lockup_o
);
    localparam int NLINES = 2;
    localparam int IDX_HOST = 0;
    localparam int IDX_CARD = 1;

    logic              active;
    logic              active_q;
    logic [NLINES-1:0] lvl_raw;
    logic [NLINES-1:0] lvl_s;
    logic [NLINES-1:0] fall;
    logic [NLINES-1:0] rise;
    dir_e              dir;

    assign active  = session_i & rx_en_i;
    assign lvl_raw = {card_line_i, host_line_i};

    // Registered enable for the card-line release.
    always_ff @(posedge clk) begin
        if (!rst_n) active_q <= 1'b0;
        else        active_q <= active;
    end

    io_arb_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (lvl_raw),
        .q_o   (lvl_s)
    );

    generate
        for (genvar i = 0; i < NLINES; i++) begin : g_edge
            io_arb_edge u_edge (
                .clk    (clk),
                .rst_n  (rst_n),
                .lvl_i  (lvl_s[i]),
                .fall_o (fall[i]),
                .rise_o (rise[i])
            );
        end
    endgenerate

    io_arb_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .active_i    (active),
        .host_fall_i (fall[IDX_HOST]),
        .host_rise_i (rise[IDX_HOST]),
        .card_fall_i (fall[IDX_CARD]),
        .card_rise_i (rise[IDX_CARD]),
        .dir_o       (dir)
    );

    io_arb_lockwd #(.CNT_W(CNT_W)) u_lockwd (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (active),
        .low_i    (~lvl_s[IDX_HOST]),
        .limit_i  (lock_limit_i),
        .lockup_o (lockup_o)
    );

    // Pull-low enables derived from direction and enable state.
    always_comb begin
        host_drive_low_o = (dir == DIR_C2H);
        card_drive_low_o = !active_q || (dir == DIR_H2C);
    end

    assign dir_o = dir;
endmodule

// File: rtl/io_arb_chk.sv
// Assertion checker for io_dir_arbiter, attached with bind.
module io_arb_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_line_i,
    input logic             session_i,
    input logic             rx_en_i,
    input logic [CNT_W-1:0] lock_limit_i,
    input logic             host_drive_low_o,
    input logic             card_drive_low_o,
    input logic [1:0]       dir_o,
    input logic             lockup_o
);
    AST_NO_DUAL_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_drive_low_o && card_drive_low_o)); // R7

    AST_DIR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        dir_o != 2'd3); // R3

    AST_INACTIVE_FORCES_NEUTRAL: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!(session_i && rx_en_i)) |->
            (dir_o == 2'd0 && card_drive_low_o && !host_drive_low_o && !lockup_o)); // R8

    AST_NO_DIRECT_SWAP_H2C: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_o == 2'd1) |=> (dir_o != 2'd2)); // R7

    AST_NO_DIRECT_SWAP_C2H: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_o == 2'd2) |=> (dir_o != 2'd1)); // R5

    AST_LOCKUP_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lockup_o) && $stable(lock_limit_i)) |-> !$past(host_line_i, 2)); // R9
endmodule

bind io_dir_arbiter io_arb_chk #(.CNT_W(CNT_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .host_line_i      (host_line_i),
    .session_i        (session_i),
    .rx_en_i          (rx_en_i),
    .lock_limit_i     (lock_limit_i),
    .host_drive_low_o (host_drive_low_o),
    .card_drive_low_o (card_drive_low_o),
    .dir_o            (dir_o),
    .lockup_o         (lockup_o)
);

// File: tb/io_dir_arbiter_tb.sv
module io_dir_arbiter_tb;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             host_ext = 1'b1;
    logic             card_ext = 1'b1;
    logic             session = 1'b0;
    logic             rx_en = 1'b0;
    logic [CNT_W-1:0] limit = 16'd1000;
    logic             host_dl, card_dl, lockup;
    logic [1:0]       dir;
    logic             host_line, card_line;

    int n_chk = 0;
    int n_bad = 0;

    // Wired-AND open-drain lines.
    assign host_line = host_ext & ~host_dl;
    assign card_line = card_ext & ~card_dl;

    always #5 clk = ~clk;

    io_dir_arbiter #(.CNT_W(CNT_W)) u_dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .host_line_i      (host_line),
        .card_line_i      (card_line),
        .session_i        (session),
        .rx_en_i          (rx_en),
        .lock_limit_i     (limit),
        .host_drive_low_o (host_dl),
        .card_drive_low_o (card_dl),
        .dir_o            (dir),
        .lockup_o         (lockup)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got dir/hdl/cdl/lock=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Packed expected view: {dir, host_drive, card_drive, lockup}
    function automatic logic [4:0] view(input logic [1:0] d, input logic h, input logic c, input logic l);
        return {d, h, c, l};
    endfunction

    function automatic logic [4:0] exp_xfer(input int kind);
        // kind 0 host first, 1 card first, 2 simultaneous
        if (kind == 1) return view(2'd2, 1'b1, 1'b0, 1'b0);
        return view(2'd1, 1'b0, 1'b1, 1'b0);
    endfunction

    function automatic logic [4:0] exp_idle();
        return view(2'd0, 1'b0, 1'b0, 1'b0);
    endfunction

    logic [4:0] now;
    assign now = {dir, host_dl, card_dl, lockup};

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        step(3);
        chk("R1 in reset", now, view(2'd0, 1'b0, 1'b1, 1'b0));
        rst_n = 1'b1;
        step(3);
        chk("R1 after reset", now, view(2'd0, 1'b0, 1'b1, 1'b0));

        // R2: session alone keeps card low; enable releases after one edge
        session = 1'b1;
        step(3);
        chk("R2 rx disabled", now, view(2'd0, 1'b0, 1'b1, 1'b0));
        rx_en = 1'b1;
        step(1);
        chk("R2 release", now, exp_idle());
        step(4);

        // R3: exact latency of host-first transfer
        host_ext = 1'b0;
        step(2);
        chk("R3 before latency", now, exp_idle());
        step(1);
        chk("R3 host to card", now, exp_xfer(0));
        // R5: release returns at third edge
        host_ext = 1'b1;
        step(2);
        chk("R5 before release", now, exp_xfer(0));
        step(1);
        chk("R5 released", now, exp_idle());
        step(4);

        // R4: card-first transfer
        card_ext = 1'b0;
        step(2);
        chk("R4 before latency", now, exp_idle());
        step(1);
        chk("R4 card to host", now, exp_xfer(1));
        card_ext = 1'b1;
        step(3);
        chk("R4 released", now, exp_idle());
        step(4);

        // R6: simultaneous falls, host wins; R7: card release does not end it
        host_ext = 1'b0;
        card_ext = 1'b0;
        step(3);
        chk("R6 host priority", now, exp_xfer(2));
        card_ext = 1'b1;
        step(5);
        chk("R7 held by host", now, exp_xfer(2));
        host_ext = 1'b1;
        step(3);
        chk("R7 end on host rise", now, exp_idle());
        step(4);

        // R9: lockup crossing with limit 5
        limit = 16'd5;
        host_ext = 1'b0;
        step(7);
        chk("R9 at limit", now, view(2'd1, 1'b0, 1'b1, 1'b0));
        step(1);
        chk("R9 over limit", now, view(2'd1, 1'b0, 1'b1, 1'b1));
        host_ext = 1'b1;
        step(2);
        chk("R9 still flagged", now[0], 1'b1);
        step(1);
        chk("R9 cleared", now, exp_idle());
        step(4);

        // R8: drop rx_en mid host transfer, with lockup up
        host_ext = 1'b0;
        step(10);
        chk("R8 pre", now, view(2'd1, 1'b0, 1'b1, 1'b1));
        rx_en = 1'b0;
        step(1);
        chk("R8 forced neutral", now, view(2'd0, 1'b0, 1'b1, 1'b0));
        step(3);
        rx_en = 1'b1;
        step(5);
        chk("R8 low at enable no transfer", now, exp_idle());
        host_ext = 1'b1;
        limit = 16'd1000;
        step(4);

        // R8: drop session mid card transfer
        card_ext = 1'b0;
        step(3);
        chk("R8 card pre", now, exp_xfer(1));
        session = 1'b0;
        step(1);
        chk("R8 session end", now, view(2'd0, 1'b0, 1'b1, 1'b0));
        card_ext = 1'b1;
        host_ext = 1'b0;
        step(4);
        chk("R8 fall ignored inactive", now, view(2'd0, 1'b0, 1'b1, 1'b0));
        host_ext = 1'b1;
        session = 1'b1;
        step(5);
        chk("R2 reenabled", now, exp_idle());

        // Random transactions
        for (int t = 0; t < 60; t++) begin
            int kind;
            int hold;
            kind = int'($urandom % 3);
            hold = 2 + int'($urandom % 30);
            if (kind != 1) host_ext = 1'b0;
            if (kind != 0) card_ext = 1'b0;
            step(4);
            chk("R3/R4/R6 random transfer", now, exp_xfer(kind));
            step(hold);
            chk("R7 random hold", now, exp_xfer(kind));
            if (kind == 2 && ($urandom % 2) == 1) begin
                card_ext = 1'b1;
                step(1 + int'($urandom % 6));
                host_ext = 1'b1;
            end else begin
                host_ext = 1'b1;
                if (kind == 2) step(1 + int'($urandom % 6));
                card_ext = 1'b1;
            end
            step(4);
            chk("R5 random release", now, exp_idle());
            step(int'($urandom % 5));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule